// File: doc/BRIEF.md
# CSMA/CD Link Access and Collision Backoff Sequencer

This block decides when a station on a shared serial line may start sending a frame, and what happens after two stations collide. It watches a line-idle indication and a collision-detect input. A pending frame starts only after the line has been quiet for a full interframe gap. A collision during sending drives a jam request for a fixed number of bit times, and then a slotted backoff. The backoff slot comes either from an 8-bit pseudo-random sequence or, in deterministic mode, from a slot number assigned to the station. The block also closes transmit and receive operations. It raises sticky done and abort flags, clears the matching enable bits and counts collisions. Software clears the flags and the count with a single pulse.

The transmit sequencer has five states. IDLE waits for transmit-enable. DEFER counts consecutive idle bit times and restarts whenever the line is busy. XMIT runs while the frame is on the line. JAM holds the jam request. BACKOFF waits out the chosen number of slots. The transitions are:
- IDLE to DEFER when transmit-enable is set.
- DEFER to XMIT after the interframe gap.
- XMIT to IDLE on a completed frame.
- XMIT to JAM on a collision.
- JAM to BACKOFF when the jam time ends.
- BACKOFF to IDLE when the target slot is reached. IDLE then re-enters DEFER if the frame is still pending.
- IDLE or DEFER to BACKOFF on a collision in deterministic mode. Here even a listening station joins the resolution and uses its assigned slot.

A receive tracker runs alongside. A collision heard while receiving drops the frame quietly if nothing has been buffered yet. If data has already been buffered, the collision aborts reception instead.

Top module: `csma_access_ctrl`

## Requirements
- R1: After reset, tx_start, jam, backoff_active, tx_enable, rx_enable, tx_done, rx_done, rx_abort and rx_drop are 0, and coll_cnt is 0.
- R2: Once tx_enable is set, tx_start pulses for exactly one cycle. The pulse comes after the sequencer has spent IFS_BITS consecutive cycles in DEFER with line_idle high. A cycle with line_idle low restarts that count. tx_start first appears IFS_BITS + max(B,1) cycles after the tx_go pulse, where B is the number of busy cycles immediately following the pulse.
- R3: In XMIT, a cycle with tfifo_empty and last_byte_sent both high and no collision sets tx_done and clears tx_enable on the next cycle.
- R4: A collision during XMIT raises jam on the next cycle and holds it for exactly JAM_BITS cycles. The same collision adds 1 to coll_cnt, which saturates at 255.
- R5: In random mode, BACKOFF lasts T*SLOT_BITS+1 cycles (backoff_active high). T is the value of an 8-bit shift register in the cycle jam ends. The register resets to 8'h01 and, every clock, shifts left with new bit 0 = q[7]^q[5]^q[4]^q[3]. The pending frame then defers again and restarts.
- R6: In deterministic mode (det_mode=1), the backoff target T is my_slot.
- R7: In deterministic mode, a collision while the sequencer is in IDLE or DEFER enters BACKOFF for my_slot*SLOT_BITS+1 cycles, even when tx_enable is 0.
- R8: In random mode, a collision while not transmitting raises neither jam nor backoff_active.
- R9: A collision while rx_enable is 1, the sequencer is outside XMIT and JAM, and rfifo_loaded is 0 pulses rx_drop for one cycle and leaves rx_enable at 1.
- R10: The same collision with rfifo_loaded at 1 clears rx_enable and sets rx_abort.
- R11: rx_eof without a collision while receiving sets rx_done and clears rx_enable.
- R12: flag_clr clears tx_done, rx_done, rx_abort and coll_cnt. A flag being set in the same cycle wins. A collision in the same cycle leaves coll_cnt at 1.
- R13: A tx_go pulse sets tx_enable and an rx_go pulse sets rx_enable. A completion or abort in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_go | input | 1 | Pulse: a frame is pending, sets tx_enable |
| rx_go | input | 1 | Pulse: sets rx_enable |
| flag_clr | input | 1 | Pulse: clears sticky flags and collision count |
| line_idle | input | 1 | Line is currently idle |
| collision | input | 1 | Collision detected on the line |
| tfifo_empty | input | 1 | Transmit FIFO is empty |
| last_byte_sent | input | 1 | Final byte has been shifted out |
| rfifo_loaded | input | 1 | Receive FIFO already holds frame data |
| rx_eof | input | 1 | End of frame detected by the receiver |
| det_mode | input | 1 | 1 = deterministic backoff, 0 = random |
| my_slot | input | SLOT_W | Assigned backoff slot for deterministic mode |
| tx_start | output | 1 | One-cycle pulse: begin sending the frame |
| jam | output | 1 | Jam request to the line coder |
| backoff_active | output | 1 | Sequencer is in BACKOFF |
| tx_enable | output | 1 | Transmit request pending |
| rx_enable | output | 1 | Reception enabled |
| tx_done | output | 1 | Sticky: transmission completed |
| rx_done | output | 1 | Sticky: reception completed |
| rx_abort | output | 1 | Sticky: reception aborted by collision |
| rx_drop | output | 1 | One-cycle pulse: unbuffered frame dropped |
| coll_cnt | output | CNT_W | Saturating collision count |

## Verification
A wrong state in the sequencer shows at the ports within one cycle. Every output flag is decoded from registered state, and the bench compares all of them against its reference model on every clock. A miscounted interframe gap moves the tx_start edge. A bad jam or slot count stretches or shortens the jam and backoff_active pulses. A corrupt random-sequence register gives the wrong backoff length at the first collision after reset. Receive-side faults surface in the cycle after the collision or end-of-frame that should have changed rx_enable, rx_drop, rx_abort or rx_done.

// File: rtl/csma_pkg.sv
package csma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF
    } link_state_t;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [7:0]  SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);
    logic [7:0] q;
    logic       fb;

    // taps for x^8 + x^6 + x^5 + x^4 + 1, maximal length
    assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[6:0], fb};
    end

    generate
        if (WIDTH >= 8) begin : g_wide
            assign value = {{(WIDTH-8){1'b0}}, q};
        end else begin : g_narrow
            assign value = q[WIDTH-1:0];
        end
    endgenerate
endmodule

// File: rtl/csma_bit_counter.sv
module csma_bit_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/csma_rx_track.sv
module csma_rx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_go,
    input  logic tx_side_busy,
    input  logic collision,
    input  logic rfifo_loaded,
    input  logic rx_eof,
    input  logic flag_clr,
    output logic rx_enable,
    output logic rx_done,
    output logic rx_abort,
    output logic rx_drop
);
    logic listening;
    logic hit_abort;
    logic hit_drop;
    logic hit_done;

    always_comb begin
        listening = rx_enable && !tx_side_busy;
        hit_abort = listening && collision && rfifo_loaded;
        hit_drop  = listening && collision && !rfifo_loaded;
        hit_done  = listening && !collision && rx_eof;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_enable <= 1'b0;
            rx_done   <= 1'b0;
            rx_abort  <= 1'b0;
            rx_drop   <= 1'b0;
        end else begin
            rx_drop <= hit_drop;
            if (hit_abort || hit_done) rx_enable <= 1'b0;
            else if (rx_go)            rx_enable <= 1'b1;
            if (hit_abort)     rx_abort <= 1'b1;
            else if (flag_clr) rx_abort <= 1'b0;
            if (hit_done)      rx_done <= 1'b1;
            else if (flag_clr) rx_done <= 1'b0;
        end
    end

    p_abort_rx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_abort) |-> !rx_enable);
    p_drop_keeps_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> rx_enable);
    p_done_rx_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> !rx_enable);
endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl
    import csma_pkg::*;
#(
    parameter int IFS_BITS  = 12,
    parameter int JAM_BITS  = 4,
    parameter int SLOT_BITS = 8,
    parameter int SLOT_W    = 8,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_go,
    input  logic              rx_go,
    input  logic              flag_clr,
    input  logic              line_idle,
    input  logic              collision,
    input  logic              tfifo_empty,
    input  logic              last_byte_sent,
    input  logic              rfifo_loaded,
    input  logic              rx_eof,
    input  logic              det_mode,
    input  logic [SLOT_W-1:0] my_slot,
    output logic              tx_start,
    output logic              jam,
    output logic              backoff_active,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              tx_done,
    output logic              rx_done,
    output logic              rx_abort,
    output logic              rx_drop,
    output logic [CNT_W-1:0]  coll_cnt
);
    localparam int TMAX0 = (IFS_BITS > JAM_BITS) ? IFS_BITS : JAM_BITS;
    localparam int TMAX  = (TMAX0 > SLOT_BITS) ? TMAX0 : SLOT_BITS;
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [TW-1:0] IFS_LAST  = TW'(IFS_BITS - 1);
    localparam logic [TW-1:0] JAM_LAST  = TW'(JAM_BITS - 1);
    localparam logic [TW-1:0] SLOT_LAST = TW'(SLOT_BITS - 1);

    link_state_t       state_q, state_d;
    logic [TW-1:0]     bit_cnt;
    logic [SLOT_W-1:0] slot_cnt;
    logic [SLOT_W-1:0] target_q;
    logic [SLOT_W-1:0] lfsr_val;
    logic              cnt_clr, cnt_inc, slot_clr, slot_inc;
    logic              load_tgt, load_own, coll_hit, tx_finish;
    logic              tx_side_busy;

    csma_lfsr #(.WIDTH(SLOT_W), .SEED(8'h01)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(lfsr_val));

    csma_bit_counter #(.W(TW)) u_bit_timer (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(bit_cnt));

    csma_bit_counter #(.W(SLOT_W)) u_slot_timer (
        .clk(clk), .rst_n(rst_n), .clr(slot_clr), .inc(slot_inc), .count(slot_cnt));

    // next-state and timer control
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        slot_clr  = 1'b0;
        slot_inc  = 1'b0;
        load_tgt  = 1'b0;
        load_own  = 1'b0;
        coll_hit  = 1'b0;
        tx_finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (det_mode && collision) begin
                    state_d  = ST_BACKOFF;
                    cnt_clr  = 1'b1;
                    slot_clr = 1'b1;
                    load_own = 1'b1;
                end else if (tx_enable) begin
                    state_d = ST_DEFER;
                    cnt_clr = 1'b1;
                end
            end
            ST_DEFER: begin
                if (det_mode && collision) begin
                    state_d  = ST_BACKOFF;
                    cnt_clr  = 1'b1;
                    slot_clr = 1'b1;
                    load_own = 1'b1;
                end else if (!line_idle) begin
                    cnt_clr = 1'b1;
                end else if (bit_cnt == IFS_LAST) begin
                    state_d = ST_XMIT;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_XMIT: begin
                if (collision) begin
                    state_d  = ST_JAM;
                    cnt_clr  = 1'b1;
                    coll_hit = 1'b1;
                end else if (tfifo_empty && last_byte_sent) begin
                    state_d   = ST_IDLE;
                    tx_finish = 1'b1;
                end
            end
            ST_JAM: begin
                if (bit_cnt == JAM_LAST) begin
                    state_d  = ST_BACKOFF;
                    cnt_clr  = 1'b1;
                    slot_clr = 1'b1;
                    load_tgt = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_BACKOFF: begin
                if (slot_cnt == target_q) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (bit_cnt == SLOT_LAST) begin
                    cnt_clr  = 1'b1;
                    slot_inc = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tx_start <= 1'b0;
        end else begin
            state_q  <= state_d;
            tx_start <= (state_q == ST_DEFER) && (state_d == ST_XMIT);
        end
    end

    // outputs decoded from state
    always_comb begin
        jam            = (state_q == ST_JAM);
        backoff_active = (state_q == ST_BACKOFF);
        tx_side_busy   = (state_q == ST_XMIT) || (state_q == ST_JAM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (load_own) begin
            target_q <= my_slot;
        end else if (load_tgt) begin
            target_q <= det_mode ? my_slot : lfsr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_enable <= 1'b0;
            tx_done   <= 1'b0;
            coll_cnt  <= '0;
        end else begin
            if (tx_finish)  tx_enable <= 1'b0;
            else if (tx_go) tx_enable <= 1'b1;
            if (tx_finish)     tx_done <= 1'b1;
            else if (flag_clr) tx_done <= 1'b0;
            if (coll_hit) begin
                if (flag_clr)              coll_cnt <= CNT_W'(1);
                else if (coll_cnt != '1)   coll_cnt <= coll_cnt + 1'b1;
            end else if (flag_clr) begin
                coll_cnt <= '0;
            end
        end
    end

    csma_rx_track u_rx (
        .clk(clk), .rst_n(rst_n), .rx_go(rx_go), .tx_side_busy(tx_side_busy),
        .collision(collision), .rfifo_loaded(rfifo_loaded), .rx_eof(rx_eof),
        .flag_clr(flag_clr), .rx_enable(rx_enable), .rx_done(rx_done),
        .rx_abort(rx_abort), .rx_drop(rx_drop));

    p_start_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(line_idle));
    p_one_role_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_start, jam, backoff_active}));
    p_jam_needs_coll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam) |-> $past(collision));
    p_coll_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XMIT && collision && !flag_clr && coll_cnt != '1)
            |=> coll_cnt == $past(coll_cnt) + 1'b1);
    p_done_drops_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> !tx_enable);
    p_det_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(backoff_active) && $past(det_mode)) |-> target_q == $past(my_slot));
endmodule

// File: tb/tb_csma_access_ctrl.sv
module tb_csma_access_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IFS  = 12;
    localparam int JAMB = 4;
    localparam int SLOT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_go = 0, rx_go = 0, flag_clr = 0, line_idle = 1, collision = 0;
    logic tfifo_empty = 0, last_byte_sent = 0, rfifo_loaded = 0, rx_eof = 0, det_mode = 0;
    logic [7:0] my_slot = 8'd0;
    logic tx_start, jam, backoff_active, tx_enable, rx_enable;
    logic tx_done, rx_done, rx_abort, rx_drop;
    logic [7:0] coll_cnt;

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;

    csma_access_ctrl #(.IFS_BITS(IFS), .JAM_BITS(JAMB), .SLOT_BITS(SLOT),
                       .SLOT_W(8), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .rx_go(rx_go), .flag_clr(flag_clr),
        .line_idle(line_idle), .collision(collision), .tfifo_empty(tfifo_empty),
        .last_byte_sent(last_byte_sent), .rfifo_loaded(rfifo_loaded), .rx_eof(rx_eof),
        .det_mode(det_mode), .my_slot(my_slot), .tx_start(tx_start), .jam(jam),
        .backoff_active(backoff_active), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .tx_done(tx_done), .rx_done(rx_done), .rx_abort(rx_abort), .rx_drop(rx_drop),
        .coll_cnt(coll_cnt));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: phase 0 idle,1 defer,2 sending,3 jamming,4 waiting slots
    int m_ph, m_cnt, m_slot, m_tgt, m_lfsr, m_coll;
    int m_txen, m_rxen, m_txdone, m_rxdone, m_abort, m_drop, m_start;
    int n_ph, n_cnt, n_slot, n_tgt, fin, hit, fb;
    bit listen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_slot = 0; m_tgt = 0; m_lfsr = 1; m_coll = 0;
            m_txen = 0; m_rxen = 0; m_txdone = 0; m_rxdone = 0; m_abort = 0;
            m_drop = 0; m_start = 0;
        end else begin
            n_ph = m_ph; n_cnt = m_cnt; n_slot = m_slot; n_tgt = m_tgt; fin = 0; hit = 0;
            if ((m_ph == 0 || m_ph == 1) && det_mode && collision) begin
                n_ph = 4; n_cnt = 0; n_slot = 0; n_tgt = my_slot;
            end else if (m_ph == 0) begin
                if (m_txen != 0) begin n_ph = 1; n_cnt = 0; end
            end else if (m_ph == 1) begin
                if (!line_idle) n_cnt = 0;
                else if (m_cnt + 1 == IFS) begin n_ph = 2; n_cnt = 0; end
                else n_cnt = m_cnt + 1;
            end else if (m_ph == 2) begin
                if (collision) begin n_ph = 3; n_cnt = 0; hit = 1; end
                else if (tfifo_empty && last_byte_sent) begin n_ph = 0; fin = 1; end
            end else if (m_ph == 3) begin
                if (m_cnt + 1 == JAMB) begin
                    n_ph = 4; n_cnt = 0; n_slot = 0;
                    n_tgt = det_mode ? int'(my_slot) : m_lfsr;
                end else n_cnt = m_cnt + 1;
            end else begin
                if (m_slot == m_tgt) begin n_ph = 0; n_cnt = 0; end
                else if (m_cnt + 1 == SLOT) begin n_cnt = 0; n_slot = m_slot + 1; end
                else n_cnt = m_cnt + 1;
            end
            listen = (m_rxen != 0) && m_ph != 2 && m_ph != 3;
            m_drop = (listen && collision && !rfifo_loaded) ? 1 : 0;
            if (listen && collision && rfifo_loaded) begin m_rxen = 0; m_abort = 1; end
            else if (listen && !collision && rx_eof) begin m_rxen = 0; m_rxdone = 1; end
            else begin
                if (rx_go) m_rxen = 1;
                if (flag_clr) begin m_abort = 0; m_rxdone = 0; end
            end
            if (listen && collision && rfifo_loaded && flag_clr) m_rxdone = 0;
            if (listen && !collision && rx_eof && flag_clr) m_abort = 0;
            m_start = (m_ph == 1 && n_ph == 2) ? 1 : 0;
            if (fin) begin m_txen = 0; m_txdone = 1; end
            else begin
                if (tx_go) m_txen = 1;
                if (flag_clr) m_txdone = 0;
            end
            if (hit) m_coll = flag_clr ? 1 : (m_coll < 255 ? m_coll + 1 : 255);
            else if (flag_clr) m_coll = 0;
            fb = ((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1;
            m_lfsr = ((m_lfsr << 1) | fb) & 255;
            m_ph = n_ph; m_cnt = n_cnt; m_slot = n_slot; m_tgt = n_tgt;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R2 tx_start vs model", tx_start, m_start);
            check("R4 jam vs model", jam, m_ph == 3);
            check("R5 backoff_active vs model", backoff_active, m_ph == 4);
            check("R13 tx_enable vs model", tx_enable, m_txen);
            check("R13 rx_enable vs model", rx_enable, m_rxen);
            check("R3 tx_done vs model", tx_done, m_txdone);
            check("R11 rx_done vs model", rx_done, m_rxdone);
            check("R10 rx_abort vs model", rx_abort, m_abort);
            check("R9 rx_drop vs model", rx_drop, m_drop);
            check("R4 coll_cnt vs model", coll_cnt, m_coll);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    // pulse tx_go, keep line busy for 'busy' cycles, return cycles until tx_start
    task automatic go_and_wait(input int busy, output int n);
        n = 0;
        tick(); tx_go = 1;
        tick(); tx_go = 0; line_idle = (busy > 0) ? 1'b0 : 1'b1;
        for (int i = 1; i < 6000; i++) begin
            tick();
            if (tx_start) begin n = i; break; end
            line_idle = (i < busy) ? 1'b0 : 1'b1;
        end
        line_idle = 1;
    endtask

    task automatic wait_start(output int ok);
        ok = 0;
        for (int i = 0; i < 6000; i++) begin
            tick();
            if (tx_start) begin ok = 1; break; end
        end
    endtask

    // called at the first XMIT cycle; returns jam and backoff lengths and model target
    task automatic collide(input bit clr_too, output int jl, output int bl, output int tg);
        collision = 1; flag_clr = clr_too;
        tick(); collision = 0; flag_clr = 0;
        jl = 0; bl = 0;
        while (jam && jl < 100) begin jl++; tick(); end
        tg = m_tgt;
        while (backoff_active && bl < 5000) begin bl++; tick(); end
    endtask

    task automatic finish_tx();
        tfifo_empty = 1; last_byte_sent = 1;
        tick(); tfifo_empty = 0; last_byte_sent = 0;
    endtask

    int n, ok, jl, bl, tg;
    bit seen;

    initial begin
        repeat (3) tick();
        check("R1 tx_start reset", tx_start, 0);
        check("R1 jam reset", jam, 0);
        check("R1 backoff reset", backoff_active, 0);
        check("R1 tx_enable reset", tx_enable, 0);
        check("R1 rx_enable reset", rx_enable, 0);
        check("R1 flags reset", {tx_done, rx_done, rx_abort, rx_drop}, 0);
        check("R1 coll_cnt reset", coll_cnt, 0);
        rst_n = 1; cmp_on = 1;

        // R2: clean line
        go_and_wait(0, n);
        check("R2 start delay idle line", n, IFS + 1);
        tick();
        check("R2 start is one cycle", tx_start, 0);
        finish_tx();
        check("R3 tx_done set", tx_done, 1);
        check("R3 tx_enable cleared", tx_enable, 0);
        flag_clr = 1; tick(); flag_clr = 0;
        check("R12 tx_done cleared", tx_done, 0);

        // R2: busy line restarts the gap
        go_and_wait(5, n);
        check("R2 start delay busy line", n, IFS + 5);

        // R4 R5: random backoff
        collide(0, jl, bl, tg);
        check("R4 jam length", jl, JAMB);
        check("R5 random backoff length", bl, tg * SLOT + 1);
        check("R4 coll_cnt one", coll_cnt, 1);
        wait_start(ok);
        check("R5 restart after backoff", ok, 1);
        collide(0, jl, bl, tg);
        check("R5 second random backoff", bl, tg * SLOT + 1);
        check("R4 coll_cnt two", coll_cnt, 2);
        wait_start(ok);
        finish_tx();
        check("R3 done after retry", tx_done, 1);

        // R6: deterministic target
        det_mode = 1; my_slot = 8'd3;
        go_and_wait(0, n);
        collide(0, jl, bl, tg);
        check("R6 det backoff length", bl, 3 * SLOT + 1);
        wait_start(ok);
        // R12: clear together with a collision
        collide(1, jl, bl, tg);
        check("R12 clear with collision", coll_cnt, 1);
        wait_start(ok);
        finish_tx();

        // R7: listener joins resolution
        my_slot = 8'd2;
        tick(); collision = 1;
        tick(); collision = 0;
        check("R7 listener enters backoff", backoff_active, 1);
        bl = 0;
        while (backoff_active && bl < 100) begin bl++; tick(); end
        check("R7 listener backoff length", bl, 2 * SLOT + 1);
        check("R7 no start without request", tx_enable, 0);

        // R8: random mode listener ignores collision
        det_mode = 0; my_slot = 8'd0;
        tick(); collision = 1;
        tick(); collision = 0;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (jam || backoff_active) seen = 1;
            tick();
        end
        check("R8 no jam or backoff", seen, 0);

        // R9 R10 R11 R13: receive side
        tick(); rx_go = 1;
        tick(); rx_go = 0;
        check("R13 rx_enable set", rx_enable, 1);
        collision = 1; rfifo_loaded = 0;
        tick(); collision = 0;
        check("R9 drop pulse", rx_drop, 1);
        check("R9 rx stays enabled", rx_enable, 1);
        tick();
        check("R9 drop one cycle", rx_drop, 0);
        collision = 1; rfifo_loaded = 1;
        tick(); collision = 0; rfifo_loaded = 0;
        check("R10 rx_enable cleared", rx_enable, 0);
        check("R10 abort set", rx_abort, 1);
        rx_go = 1;
        tick(); rx_go = 0; rx_eof = 1;
        tick(); rx_eof = 0;
        check("R11 rx_done set", rx_done, 1);
        check("R11 rx_enable cleared", rx_enable, 0);
        flag_clr = 1; tick(); flag_clr = 0;
        check("R12 rx flags cleared", {rx_done, rx_abort}, 0);
        check("R12 coll_cnt cleared", coll_cnt, 0);

        // R4: saturation with one-cycle deterministic backoff
        det_mode = 1; my_slot = 8'd0;
        go_and_wait(0, n);
        for (int k = 0; k < 258; k++) begin
            collide(0, jl, bl, tg);
            wait_start(ok);
        end
        check("R4 coll_cnt saturates", coll_cnt, 255);
        finish_tx();
        check("R3 final done", tx_done, 1);
        repeat (3) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check("watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule